// File: doc/BRIEF.md
# Bit Clock and Frame Sync Generator

This block produces the serial bit clock and the frame sync for a serial audio port that is clock and frame master. A reference clock is divided by an integer ratio to form the bit clock. A frame counter advances once per bit clock. It raises the frame sync at the start of every frame and holds it for a programmable number of bit clocks. A one-cycle strobe in the reference domain marks the first reference cycle of each frame. The bit clock and the frame sync each have a polarity control. An enable input stops both counters and parks the outputs at their inactive levels.

Period, width and divider are all written as their value minus one. A combinational configuration helper sits beside the generator and produces the frame period and the sync width fields from the system parameters. For a master port it derives the frame length from the reference frequency, the divide ratio and the sample rate. For a slave port it derives the frame length from word length times channel count. The helper also raises a flag when a master frame is too short to carry all the channel words. A format that uses a half-frame sync gets a width field of half the frame. A pulse format gets a width field of zero, which is a single bit clock.

Top module: `bclk_fsync_gen`

## Requirements
- R1: While reset is low, and after it is released with enable low, bclk equals bclkInvert, fsync equals fsyncInvert, and frameStart is 0.
- R2: With divMinus1 = M, the bit clock repeats every M+1 reference cycles. It is high (before inversion) for the first (M+2)/2 reference cycles of each period, rounded down. An odd ratio therefore keeps the extra cycle in the high phase, and M = 0 holds it high.
- R3: With periodMinus1 = P and widthMinus1 = W, the frame repeats every P+1 bit clocks. The frame sync is active (before inversion) during bit clocks 0 through W of each frame.
- R4: frameStart is high for exactly one reference cycle per frame: the first reference cycle of bit clock 0, which is also where the bit clock goes high.
- R5: bclkInvert = 1 inverts the bit clock output and fsyncInvert = 1 inverts the frame sync output. The invert inputs change nothing else.
- R6: One cycle after enable is sampled low, the outputs are at their inactive levels and both counters return to zero. At the first enabled clock edge the first frame starts, and it shows at the outputs one cycle later.
- R7: In master mode (isMaster = 1) the helper's frame length is floor(floor(refFreq / ratio) / sampleRate). A cfgDivRatio of 0 counts as a ratio of 1, and a sampleRate of 0 gives a length of 0.
- R8: In slave mode (isMaster = 0) the helper's frame length is wordLen × chanCount.
- R9: cfgBwError is 1 exactly when isMaster = 1 and the frame length is below wordLen × chanCount.
- R10: cfgPeriodMinus1 is the frame length minus one, with 0 for a zero length, and it saturates at 4095. cfgWidthMinus1 is half the frame length (rounded down) minus one when halfWidthFmt = 1, with 0 when that half is 0, and it saturates at 255. With halfWidthFmt = 0 it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator when high |
| divMinus1 | input | 8 | Bit clock divide ratio minus one |
| periodMinus1 | input | 12 | Frame period in bit clocks minus one |
| widthMinus1 | input | 8 | Frame sync width in bit clocks minus one |
| bclkInvert | input | 1 | Inverts the bit clock output |
| fsyncInvert | input | 1 | Inverts the frame sync output |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| frameStart | output | 1 | One-reference-cycle frame start strobe |
| isMaster | input | 1 | Helper: port generates the clocks |
| halfWidthFmt | input | 1 | Helper: half-frame sync (1) or one-bit pulse (0) |
| refFreq | input | 32 | Helper: reference frequency in Hz |
| sampleRate | input | 20 | Helper: sample rate in Hz |
| cfgDivRatio | input | 8 | Helper: divide ratio (0 counts as 1) |
| wordLen | input | 6 | Helper: bits per word |
| chanCount | input | 5 | Helper: words per frame |
| cfgPeriodMinus1 | output | 12 | Helper: derived frame period field |
| cfgWidthMinus1 | output | 8 | Helper: derived sync width field |
| cfgBwError | output | 1 | Helper: frame too short for the words |

## Verification
Three cases are the hard ones to reach: an odd divide ratio, where the bit clock's high phase is one cycle longer than its low phase; a sync width equal to the whole frame; and a stop in the middle of a frame, after which the first frame must start again at once. The stimulus sweeps every combination of small divide ratio, frame period and sync width, with polarity varying from case to case. Expected levels are computed from the count of reference cycles since enable. A separate run drops enable inside a frame and checks the restart cycle by cycle. The helper is driven with values chosen to land exactly on the saturation limits, on a zero ratio, a zero rate and a frame that is one bit short.

// File: rtl/bclk_fsync_pkg.sv
package bclk_fsync_pkg;

  // Per-cycle levels decided by the control, registered by the datapath.
  typedef struct packed {
    logic running;     // generator enabled this cycle
    logic bitLevel;    // bit clock level before polarity
    logic syncLevel;   // frame sync level before polarity
    logic frameMark;   // first reference cycle of a frame
  } bfsStrobe_t;

endpackage

// File: rtl/bfs_cfg_calc.sv
module bfs_cfg_calc #(
  parameter int FREQ_W = 32,
  parameter int RATE_W = 20,
  parameter int DIV_W  = 8,
  parameter int WLEN_W = 6,
  parameter int CHAN_W = 5,
  parameter int PER_W  = 12,
  parameter int FSW_W  = 8
) (
  input  logic              isMaster,
  input  logic              halfWidthFmt,
  input  logic [FREQ_W-1:0] refFreq,
  input  logic [RATE_W-1:0] sampleRate,
  input  logic [DIV_W-1:0]  divRatio,
  input  logic [WLEN_W-1:0] wordLen,
  input  logic [CHAN_W-1:0] chanCount,
  output logic [PER_W-1:0]  periodMinus1,
  output logic [FSW_W-1:0]  widthMinus1,
  output logic              bwError
);

  localparam int SLOT_W = WLEN_W + CHAN_W;
  localparam logic [FREQ_W-1:0] PER_MAX = FREQ_W'({PER_W{1'b1}});
  localparam logic [FREQ_W-1:0] FSW_MAX = FREQ_W'({FSW_W{1'b1}});

  logic [FREQ_W-1:0] effRatio;
  logic [FREQ_W-1:0] bitRate;
  logic [FREQ_W-1:0] masterLen;
  logic [SLOT_W-1:0] slotBits;
  logic [FREQ_W-1:0] slotBitsW;
  logic [FREQ_W-1:0] frameLen;
  logic [FREQ_W-1:0] lenMinus1;
  logic [FREQ_W-1:0] halfLen;
  logic [FREQ_W-1:0] halfMinus1;

  assign effRatio  = (divRatio == '0) ? FREQ_W'(1) : FREQ_W'(divRatio);
  assign bitRate   = refFreq / effRatio;
  assign masterLen = (sampleRate == '0) ? '0 : bitRate / FREQ_W'(sampleRate);
  assign slotBits  = SLOT_W'(wordLen) * SLOT_W'(chanCount);
  assign slotBitsW = FREQ_W'(slotBits);
  assign frameLen  = isMaster ? masterLen : slotBitsW;
  assign bwError   = isMaster && (masterLen < slotBitsW);

  assign lenMinus1  = frameLen - FREQ_W'(1);
  assign halfLen    = frameLen >> 1;
  assign halfMinus1 = halfLen - FREQ_W'(1);

  always_comb begin
    if (frameLen == '0)          periodMinus1 = '0;
    else if (lenMinus1 > PER_MAX) periodMinus1 = '1;
    else                          periodMinus1 = lenMinus1[PER_W-1:0];

    if (!halfWidthFmt || halfLen == '0) widthMinus1 = '0;
    else if (halfMinus1 > FSW_MAX)       widthMinus1 = '1;
    else                                 widthMinus1 = halfMinus1[FSW_W-1:0];
  end

  // A derived sync never outlasts the derived frame.
  always_comb begin
    if (halfWidthFmt)
      AST_WIDTH_FITS: assert (FREQ_W'(widthMinus1) <= FREQ_W'(periodMinus1)); // R10
  end

endmodule

// File: rtl/bfs_ctrl.sv
module bfs_ctrl
  import bclk_fsync_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PER_W = 12,
  parameter int FSW_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divMinus1,
  input  logic [PER_W-1:0] periodMinus1,
  input  logic [FSW_W-1:0] widthMinus1,
  output bfsStrobe_t       strobe
);

  localparam int CMP_W = (PER_W > FSW_W) ? PER_W : FSW_W;

  logic [DIV_W-1:0] divCnt;
  logic [PER_W-1:0] bitCnt;
  logic [DIV_W:0]   highCycles;
  logic             divWrap;
  logic             frameWrap;

  // Odd ratios keep the extra reference cycle in the high phase.
  assign highCycles = ({1'b0, divMinus1} + (DIV_W + 1)'(2)) >> 1;
  assign divWrap    = divCnt >= divMinus1;
  assign frameWrap  = bitCnt >= periodMinus1;

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      divCnt <= '0;
      bitCnt <= '0;
    end else begin
      divCnt <= divWrap ? '0 : divCnt + DIV_W'(1);
      if (divWrap)
        bitCnt <= frameWrap ? '0 : bitCnt + PER_W'(1);
    end
  end

  always_comb begin
    strobe.running   = enable;
    strobe.bitLevel  = enable && ({1'b0, divCnt} < highCycles);
    strobe.syncLevel = enable && (CMP_W'(bitCnt) <= CMP_W'(widthMinus1));
    strobe.frameMark = enable && (divCnt == '0) && (bitCnt == '0);
  end

  AST_DIV_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && divCnt == divMinus1) |=> (divCnt == '0)); // R2

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && divCnt == divMinus1 && bitCnt == periodMinus1) |=> (bitCnt == '0)); // R3

endmodule

// File: rtl/bfs_dpath.sv
module bfs_dpath
  import bclk_fsync_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  bfsStrobe_t strobe,
  input  logic       bclkInvert,
  input  logic       fsyncInvert,
  output logic       bclk,
  output logic       fsync,
  output logic       frameStart
);

  logic bitQ;
  logic syncQ;
  logic markQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitQ  <= 1'b0;
      syncQ <= 1'b0;
      markQ <= 1'b0;
    end else begin
      bitQ  <= strobe.bitLevel;
      syncQ <= strobe.syncLevel;
      markQ <= strobe.frameMark;
    end
  end

  assign bclk       = bitQ ^ bclkInvert;
  assign fsync      = syncQ ^ fsyncInvert;
  assign frameStart = markQ;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.running |=> (!bitQ && !syncQ && !markQ)); // R6

  AST_MARK_ON_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    markQ |-> (bitQ && syncQ)); // R4

  AST_FIRST_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.running) |=> markQ); // R6

endmodule

// File: rtl/bclk_fsync_gen.sv
module bclk_fsync_gen
  import bclk_fsync_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int PER_W  = 12,
  parameter int FSW_W  = 8,
  parameter int FREQ_W = 32,
  parameter int RATE_W = 20,
  parameter int WLEN_W = 6,
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divMinus1,
  input  logic [PER_W-1:0]  periodMinus1,
  input  logic [FSW_W-1:0]  widthMinus1,
  input  logic              bclkInvert,
  input  logic              fsyncInvert,
  output logic              bclk,
  output logic              fsync,
  output logic              frameStart,
  input  logic              isMaster,
  input  logic              halfWidthFmt,
  input  logic [FREQ_W-1:0] refFreq,
  input  logic [RATE_W-1:0] sampleRate,
  input  logic [DIV_W-1:0]  cfgDivRatio,
  input  logic [WLEN_W-1:0] wordLen,
  input  logic [CHAN_W-1:0] chanCount,
  output logic [PER_W-1:0]  cfgPeriodMinus1,
  output logic [FSW_W-1:0]  cfgWidthMinus1,
  output logic              cfgBwError
);

  bfsStrobe_t strobe;

  bfs_ctrl #(.DIV_W(DIV_W), .PER_W(PER_W), .FSW_W(FSW_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .divMinus1    (divMinus1),
    .periodMinus1 (periodMinus1),
    .widthMinus1  (widthMinus1),
    .strobe       (strobe)
  );

  bfs_dpath uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .bclkInvert  (bclkInvert),
    .fsyncInvert (fsyncInvert),
    .bclk        (bclk),
    .fsync       (fsync),
    .frameStart  (frameStart)
  );

  bfs_cfg_calc #(
    .FREQ_W(FREQ_W), .RATE_W(RATE_W), .DIV_W(DIV_W), .WLEN_W(WLEN_W),
    .CHAN_W(CHAN_W), .PER_W(PER_W), .FSW_W(FSW_W)
  ) uCfg (
    .isMaster     (isMaster),
    .halfWidthFmt (halfWidthFmt),
    .refFreq      (refFreq),
    .sampleRate   (sampleRate),
    .divRatio     (cfgDivRatio),
    .wordLen      (wordLen),
    .chanCount    (chanCount),
    .periodMinus1 (cfgPeriodMinus1),
    .widthMinus1  (cfgWidthMinus1),
    .bwError      (cfgBwError)
  );

endmodule

// File: tb/bclk_fsync_gen_test.sv
`timescale 1ns/1ps
module bclk_fsync_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  divMinus1 = '0;
  logic [11:0] periodMinus1 = '0;
  logic [7:0]  widthMinus1 = '0;
  logic        bclkInvert = 1'b1;
  logic        fsyncInvert = 1'b1;
  logic        bclk, fsync, frameStart;
  logic        isMaster = 1'b0;
  logic        halfWidthFmt = 1'b0;
  logic [31:0] refFreq = '0;
  logic [19:0] sampleRate = '0;
  logic [7:0]  cfgDivRatio = '0;
  logic [5:0]  wordLen = '0;
  logic [4:0]  chanCount = '0;
  logic [11:0] cfgPeriodMinus1;
  logic [7:0]  cfgWidthMinus1;
  logic        cfgBwError;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bclk_fsync_gen uut (
    .clk(clk), .rstN(rstN), .enable(enable), .divMinus1(divMinus1),
    .periodMinus1(periodMinus1), .widthMinus1(widthMinus1),
    .bclkInvert(bclkInvert), .fsyncInvert(fsyncInvert),
    .bclk(bclk), .fsync(fsync), .frameStart(frameStart),
    .isMaster(isMaster), .halfWidthFmt(halfWidthFmt), .refFreq(refFreq),
    .sampleRate(sampleRate), .cfgDivRatio(cfgDivRatio), .wordLen(wordLen),
    .chanCount(chanCount), .cfgPeriodMinus1(cfgPeriodMinus1),
    .cfgWidthMinus1(cfgWidthMinus1), .cfgBwError(cfgBwError)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Expected output levels j reference cycles after the first enabled edge.
  task automatic checkRun(string req, int r, int p, int w, int j);
    bit expBit, expSync, expMark;
    expBit  = ((j % r) < (r + 1) / 2);
    expSync = (((j / r) % p) < w);
    expMark = ((j % (r * p)) == 0);
    check(req, "bclk", bclk, expBit ^ bclkInvert);
    check(req, "fsync", fsync, expSync ^ fsyncInvert);
    check(req, "frameStart", frameStart, expMark);
  endtask

  task automatic checkIdle(string req);
    check(req, "idle bclk", bclk, bclkInvert);
    check(req, "idle fsync", fsync, fsyncInvert);
    check(req, "idle frameStart", frameStart, 0);
  endtask

  task automatic checkCfg(string req, bit m, bit h, longint rf, longint sr,
                          longint dr, longint wl, longint ch);
    longint ratio, len, slot, expPer, expWid;
    bit expErr;
    isMaster = m; halfWidthFmt = h; refFreq = 32'(rf); sampleRate = 20'(sr);
    cfgDivRatio = 8'(dr); wordLen = 6'(wl); chanCount = 5'(ch);
    #1;
    ratio = (dr == 0) ? 1 : dr;
    slot  = wl * ch;
    if (m) len = (sr == 0) ? 0 : (rf / ratio) / sr;
    else   len = slot;
    expErr = m && (len < slot);
    expPer = (len == 0) ? 0 : ((len - 1 > 4095) ? 4095 : len - 1);
    if (!h || len / 2 == 0) expWid = 0;
    else expWid = (len / 2 - 1 > 255) ? 255 : len / 2 - 1;
    check(req, "cfgPeriodMinus1", cfgPeriodMinus1, expPer);
    check(req, "cfgWidthMinus1", cfgWidthMinus1, expWid);
    check(req, "cfgBwError", cfgBwError, expErr);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state with both polarities inverted
    repeat (3) @(negedge clk);
    checkIdle("R1");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("R1");

    // R2 R3 R4 R5: sweep of divide ratio, frame period and width
    for (int r = 1; r <= 5; r++) begin
      for (int p = 2; p <= 5; p++) begin
        for (int w = 1; w <= p; w++) begin
          divMinus1    = 8'(r - 1);
          periodMinus1 = 12'(p - 1);
          widthMinus1  = 8'(w - 1);
          bclkInvert   = 1'((r + p + w) & 1);
          fsyncInvert  = 1'(((r + p + w) >> 1) & 1);
          @(negedge clk);
          checkIdle("R5");
          enable = 1'b1;
          for (int j = 0; j < 2 * r * p; j++) begin
            @(negedge clk);
            if (w == p) checkRun("R3", r, p, w, j);
            else if (r % 2 == 1) checkRun("R2", r, p, w, j);
            else checkRun("R4", r, p, w, j);
          end
          enable = 1'b0;
          @(negedge clk);
          checkIdle("R6");
        end
      end
    end

    // R6: stop inside a frame and restart
    divMinus1 = 8'd2; periodMinus1 = 12'd3; widthMinus1 = 8'd1;
    bclkInvert = 1'b0; fsyncInvert = 1'b0;
    enable = 1'b1;
    for (int j = 0; j < 7; j++) begin
      @(negedge clk);
      checkRun("R6", 3, 4, 2, j);
    end
    enable = 1'b0;
    @(negedge clk);
    checkIdle("R6");
    enable = 1'b1;
    for (int j = 0; j < 24; j++) begin
      @(negedge clk);
      checkRun("R6", 3, 4, 2, j);
    end
    enable = 1'b0;
    @(negedge clk);

    // R7 R8 R9 R10: configuration helper
    checkCfg("R7", 1, 1, 12288000, 48000, 4, 16, 2);
    checkCfg("R7", 1, 1, 12288000, 48000, 0, 16, 2);
    checkCfg("R9", 1, 1, 12288000, 48000, 4, 32, 4);
    checkCfg("R9", 1, 0, 12288000, 48000, 4, 16, 4);
    checkCfg("R9", 1, 0, 12288000, 48000, 4, 13, 5);
    checkCfg("R7", 1, 1, 12288000, 0, 4, 16, 2);
    checkCfg("R10", 1, 1, 100000000, 8000, 1, 16, 2);
    checkCfg("R10", 1, 1, 40960000, 10000, 1, 16, 2);
    checkCfg("R10", 1, 1, 40970000, 10000, 1, 16, 2);
    checkCfg("R10", 1, 1, 5120000, 10000, 1, 8, 2);
    checkCfg("R10", 1, 1, 5140000, 10000, 1, 8, 2);
    checkCfg("R8", 0, 1, 12288000, 48000, 4, 16, 2);
    checkCfg("R8", 0, 0, 0, 0, 0, 32, 8);
    checkCfg("R8", 0, 1, 0, 0, 0, 1, 1);
    checkCfg("R9", 0, 1, 1000, 48000, 1, 32, 16);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule